// File: doc/BRIEF.md
# ADC Gain Calibration Sequencer

This block is the digital controller that runs a gain calibration pass for a multi-channel ADC. Software first issues a soft reset and then sets a calibration-start bit. The sequencer records which channels are enabled and which gain each one uses at that moment. It then visits the channels in ascending order. For each enabled channel whose gain has not yet been measured in this pass, it makes a request to the analog cell over a request/acknowledge handshake. The correction word that comes back is written into a small store that is indexed by gain setting, not by channel.

When the pass completes, an end-of-calibration flag is set in the status word. This flag drives an interrupt when the interrupt enable is on. Reading the status word clears the flag. Conversions look up the correction for their gain on a separate combinational port. Because entries are keyed by gain, a channel enabled later with an already calibrated gain is covered without a new pass. A soft reset invalidates every entry. Writes that only change the running mode leave the store alone.

Top module: `adc_cal_seq`

## Requirements
- R1: A start request (control word, address 0, bit 1) is accepted only if a soft reset (address 0, bit 0) has been written since the last accepted start. If both bits are set in one write, the soft reset wins and the start is dropped. An unaccepted start causes no analog request and does not raise busy.
- R2: `cal_busy` rises on the clock edge that accepts a start. It stays high until the edge that sets end-of-calibration, and falls on that same edge. Start writes while busy have no effect, so one pass makes one set of requests.
- R3: During a pass, channels are visited in ascending number order. A request is issued only for a channel whose bit was set in the channel-enable word (address 1, bit i = channel i) when the pass started. `ana_ch` and `ana_gain` carry that channel and its gain.
- R4: Within a pass, a channel whose gain was already measured earlier in the same pass gets no request.
- R5: The channel-enable word and the gain word (address 2, channel i's gain in bits [2i+1:2i]) are captured when the pass starts. Writing either of them during the pass does not change the pass.
- R6: When `ana_ack` is high while `ana_req` is high, `ana_corr` is stored in the entry for the current gain and that entry becomes valid. `conv_corr`/`conv_valid` return the entry for `conv_gain`.
- R7: Completion sets end-of-calibration (status bit 0 at address 0). A read of address 0 returns the flag and clears it. Status bit 1 mirrors busy and bit 2 shows that a start is armed.
- R8: `irq` is high exactly while end-of-calibration is set and the interrupt enable (address 3, bit 0) is set.
- R9: A soft reset marks all four stored entries invalid and arms the next start.
- R10: A mode write (address 0, bit 2 set, mode value in bits [5:4], read back at address 3 bits [5:4]) leaves the stored entries unchanged.
- R11: After reset, busy, irq, end-of-calibration and armed are 0 and no entry is valid.
- R12: Once raised, `ana_req` stays high with a steady channel and gain until `ana_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe (clears end-of-calibration on address 0) |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Read data, combinational from rd_addr |
| cal_busy | output | 1 | Pass in progress |
| irq | output | 1 | End-of-calibration interrupt |
| ana_req | output | 1 | Measurement request to analog cell |
| ana_ch | output | CHW | Channel being measured |
| ana_gain | output | GW | Gain setting being measured |
| ana_ack | input | 1 | Analog cell result strobe |
| ana_corr | input | CW | Signed correction word from analog cell |
| conv_gain | input | GW | Gain of the conversion needing a correction |
| conv_corr | output | CW | Stored correction for conv_gain |
| conv_valid | output | 1 | Entry for conv_gain is valid |

## Verification
The hardest case to reach is a pass whose inputs change while it is running. In that case the enable and gain words are rewritten, or a second start is written, between requests. The bench's analog responder holds every acknowledge for several cycles, so the pass stays busy long enough to land those writes mid-pass. The requests it logs are then compared with a sequence the bench derives from the configuration that held at the start. A table of enable/gain patterns exercises the skip rules, including the repeated-gain, empty and all-distinct cases.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_REQ, ST_DONE} cal_state_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CHEN = 2'd1;
  localparam logic [1:0] A_GAIN = 2'd2;
  localparam logic [1:0] A_CFG  = 2'd3;

  localparam int B_SWRST  = 0;
  localparam int B_START  = 1;
  localparam int B_MODEWR = 2;
  localparam int B_MODE   = 4;
  localparam int MODE_W   = 2;
endpackage

// File: rtl/adc_cal_regs.sv
module adc_cal_regs
  import adc_cal_pkg::*;
#(
  parameter int NCH = 8,
  parameter int GW  = 2,
  parameter int DW  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [1:0]        rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              busy,
  input  logic              pass_done,
  output logic [NCH-1:0]    chen,
  output logic [NCH*GW-1:0] gain_cfg,
  output logic              swrst,
  output logic              start_go,
  output logic              mode_wr,
  output logic              armed,
  output logic              irq
);
  localparam int GCW = NCH * GW;

  logic [NCH-1:0]    chen_q, chen_d;
  logic [GCW-1:0]    gain_q, gain_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              ier_q, ier_d;
  logic              eoc_q, eoc_d;
  logic              armed_q, armed_d;
  logic              wr_ctrl, stat_rd;

  assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
  assign swrst    = wr_ctrl && wr_data[B_SWRST];
  assign start_go = wr_ctrl && wr_data[B_START] && !wr_data[B_SWRST] && armed_q && !busy;
  assign mode_wr  = wr_ctrl && wr_data[B_MODEWR];
  assign stat_rd  = rd_en && (rd_addr == A_CTRL);

  always_comb begin
    chen_d  = chen_q;
    gain_d  = gain_q;
    mode_d  = mode_q;
    ier_d   = ier_q;
    eoc_d   = eoc_q;
    armed_d = armed_q;
    if (wr_en && wr_addr == A_CHEN) chen_d = wr_data[NCH-1:0];
    if (wr_en && wr_addr == A_GAIN) gain_d = wr_data[GCW-1:0];
    if (wr_en && wr_addr == A_CFG)  ier_d  = wr_data[0];
    if (mode_wr) mode_d = wr_data[B_MODE +: MODE_W];
    if (swrst) begin
      eoc_d   = 1'b0;
      armed_d = 1'b1;
    end else begin
      if (start_go) armed_d = 1'b0;
      if (pass_done)    eoc_d = 1'b1;
      else if (stat_rd) eoc_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chen_q  <= '0;
      gain_q  <= '0;
      mode_q  <= '0;
      ier_q   <= 1'b0;
      eoc_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      chen_q  <= chen_d;
      gain_q  <= gain_d;
      mode_q  <= mode_d;
      ier_q   <= ier_d;
      eoc_q   <= eoc_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL: rd_data[2:0] = {armed_q, busy, eoc_q};
      A_CHEN: rd_data[NCH-1:0] = chen_q;
      A_GAIN: rd_data[GCW-1:0] = gain_q;
      default: begin
        rd_data[0] = ier_q;
        rd_data[B_MODE +: MODE_W] = mode_q;
      end
    endcase
  end

  assign chen     = chen_q;
  assign gain_cfg = gain_q;
  assign armed    = armed_q;
  assign irq      = eoc_q && ier_q;

  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy); // R8
endmodule

// File: rtl/adc_cal_walker.sv
module adc_cal_walker
  import adc_cal_pkg::*;
#(
  parameter int NCH   = 8,
  parameter int GAINS = 4,
  parameter int CW    = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_go,
  input  logic                      abort,
  input  logic [NCH-1:0]            chen_cfg,
  input  logic [NCH*$clog2(GAINS)-1:0] gain_cfg,
  output logic                      busy,
  output logic                      pass_done,
  output logic                      ana_req,
  output logic [$clog2(NCH)-1:0]    ana_ch,
  output logic [$clog2(GAINS)-1:0]  ana_gain,
  input  logic                      ana_ack,
  input  logic [CW-1:0]             ana_corr,
  output logic                      st_we,
  output logic [$clog2(GAINS)-1:0]  st_idx,
  output logic [CW-1:0]             st_data
);
  localparam int CHW = $clog2(NCH);
  localparam int GW  = $clog2(GAINS);
  localparam logic [CHW-1:0] LAST = CHW'(NCH - 1);

  cal_state_e         state_q, state_d;
  logic [CHW-1:0]     idx_q, idx_d;
  logic [NCH-1:0]     chen_q, chen_d;
  logic [NCH*GW-1:0]  gain_q, gain_d;
  logic [GAINS-1:0]   done_q, done_d;
  logic [GW-1:0]      cur_gain;
  logic               at_last;

  assign cur_gain = gain_q[idx_q*GW +: GW];
  assign at_last  = (idx_q == LAST);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    chen_d  = chen_q;
    gain_d  = gain_q;
    done_d  = done_q;
    if (abort) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (start_go) begin
          state_d = ST_SCAN;
          idx_d   = '0;
          chen_d  = chen_cfg;
          gain_d  = gain_cfg;
          done_d  = '0;
        end
        ST_SCAN: begin
          if (chen_q[idx_q] && !done_q[cur_gain]) state_d = ST_REQ;
          else if (at_last)                       state_d = ST_DONE;
          else                                    idx_d   = idx_q + 1'b1;
        end
        ST_REQ: if (ana_ack) begin
          done_d[cur_gain] = 1'b1;
          if (at_last) state_d = ST_DONE;
          else begin
            state_d = ST_SCAN;
            idx_d   = idx_q + 1'b1;
          end
        end
        ST_DONE: state_d = ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      chen_q  <= '0;
      gain_q  <= '0;
      done_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      chen_q  <= chen_d;
      gain_q  <= gain_d;
      done_q  <= done_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign pass_done = (state_q == ST_DONE) && !abort;
  assign ana_req   = (state_q == ST_REQ);
  assign ana_ch    = idx_q;
  assign ana_gain  = cur_gain;
  assign st_we     = ana_req && ana_ack && !abort;
  assign st_idx    = cur_gain;
  assign st_data   = ana_corr;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ana_req && !ana_ack && !abort) |=> (ana_req && $stable(ana_ch) && $stable(ana_gain))); // R12
endmodule

// File: rtl/adc_cal_store.sv
module adc_cal_store #(
  parameter int GAINS = 4,
  parameter int CW    = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [$clog2(GAINS)-1:0] widx,
  input  logic [CW-1:0]            wdata,
  input  logic [$clog2(GAINS)-1:0] ridx,
  output logic [CW-1:0]            rdata,
  output logic                     rvalid,
  output logic [GAINS-1:0]         valid_vec
);
  localparam int GW = $clog2(GAINS);

  logic [CW-1:0] corr_arr [GAINS];

  for (genvar g = 0; g < GAINS; g++) begin : g_ent
    logic          v_q, v_d;
    logic [CW-1:0] c_q, c_d;
    logic          hit;

    assign hit = we && (widx == GW'(g));

    always_comb begin
      v_d = v_q;
      c_d = c_q;
      if (clr) v_d = 1'b0;
      else if (hit) begin
        v_d = 1'b1;
        c_d = wdata;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        c_q <= '0;
      end else begin
        v_q <= v_d;
        c_q <= c_d;
      end
    end

    assign valid_vec[g] = v_q;
    assign corr_arr[g]  = c_q;
  end

  assign rdata  = corr_arr[ridx];
  assign rvalid = valid_vec[ridx];

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_vec == '0)); // R9
endmodule

// File: rtl/adc_cal_seq.sv
module adc_cal_seq #(
  parameter int NCH   = 8,
  parameter int GAINS = 4,
  parameter int CW    = 12,
  parameter int DW    = 16,
  localparam int CHW  = $clog2(NCH),
  localparam int GW   = $clog2(GAINS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [1:0]     wr_addr,
  input  logic [DW-1:0]  wr_data,
  input  logic           rd_en,
  input  logic [1:0]     rd_addr,
  output logic [DW-1:0]  rd_data,
  output logic           cal_busy,
  output logic           irq,
  output logic           ana_req,
  output logic [CHW-1:0] ana_ch,
  output logic [GW-1:0]  ana_gain,
  input  logic           ana_ack,
  input  logic [CW-1:0]  ana_corr,
  input  logic [GW-1:0]  conv_gain,
  output logic [CW-1:0]  conv_corr,
  output logic           conv_valid
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic [NCH-1:0]    chen;
  logic [NCH*GW-1:0] gain_cfg;
  logic              swrst, start_go, mode_wr, armed, busy, pass_done;
  logic              st_we;
  logic [GW-1:0]     st_idx;
  logic [CW-1:0]     st_data;
  logic [GAINS-1:0]  valid_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  adc_cal_regs #(.NCH(NCH), .GW(GW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .pass_done(pass_done),
    .chen(chen), .gain_cfg(gain_cfg),
    .swrst(swrst), .start_go(start_go), .mode_wr(mode_wr),
    .armed(armed), .irq(irq)
  );

  adc_cal_walker #(.NCH(NCH), .GAINS(GAINS), .CW(CW)) u_walk (
    .clk(clk), .rst_n(rst_i_n),
    .start_go(start_go), .abort(swrst),
    .chen_cfg(chen), .gain_cfg(gain_cfg),
    .busy(busy), .pass_done(pass_done),
    .ana_req(ana_req), .ana_ch(ana_ch), .ana_gain(ana_gain),
    .ana_ack(ana_ack), .ana_corr(ana_corr),
    .st_we(st_we), .st_idx(st_idx), .st_data(st_data)
  );

  adc_cal_store #(.GAINS(GAINS), .CW(CW)) u_store (
    .clk(clk), .rst_n(rst_i_n),
    .clr(swrst), .we(st_we), .widx(st_idx), .wdata(st_data),
    .ridx(conv_gain), .rdata(conv_corr), .rvalid(conv_valid),
    .valid_vec(valid_vec)
  );

  assign cal_busy = busy;

  AST_START_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(busy) |-> $past(armed)); // R1
  AST_EOC_AT_FALL: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($fell(busy) && !$past(swrst)) |-> rd_en || rd_addr != 2'd0 || rd_data[0]); // R2
  AST_MODE_KEEPS_STORE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_wr && !swrst && !st_we) |=> $stable(valid_vec)); // R10
endmodule

// File: tb/adc_cal_seq_tb_top.sv
module adc_cal_seq_tb_top;
  localparam int DW = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        cal_busy, irq, ana_req;
  logic [2:0]  ana_ch;
  logic [1:0]  ana_gain;
  logic        ana_ack = 1'b0;
  logic [11:0] ana_corr = '0;
  logic [1:0]  conv_gain = '0;
  logic [11:0] conv_corr;
  logic        conv_valid;

  int checks = 0;
  int errs = 0;
  int log_n = 0;
  int log_ch [32];
  int log_g  [32];
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  adc_cal_seq dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .cal_busy(cal_busy), .irq(irq),
    .ana_req(ana_req), .ana_ch(ana_ch), .ana_gain(ana_gain),
    .ana_ack(ana_ack), .ana_corr(ana_corr),
    .conv_gain(conv_gain), .conv_corr(conv_corr), .conv_valid(conv_valid)
  );

  // chen[31:24] gains[23:8] expected requests[7:4] expected valid mask[3:0]
  localparam logic [31:0] VECS [5] = '{
    32'hFF0000_11, 32'h81C001_2A, 32'h3C04A0_37, 32'h005555_00, 32'hF0E403_4F
  };

  function automatic logic [11:0] corr_of(int ch, int g);
    logic [2:0] c3 = ch[2:0];
    logic [1:0] g2 = g[1:0];
    return {g2, 2'b10, c3, 5'b10101};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wait_idle(string req);
    int t = 0;
    while (cal_busy && t < 2000) begin @(negedge clk); t++; end
    check(req, 32'(t < 2000), 32'd1);
  endtask

  // analog responder: acknowledges each request after three cycles
  initial begin
    forever begin
      @(negedge clk);
      if (ana_req) begin
        log_ch[log_n] = int'(ana_ch);
        log_g[log_n]  = int'(ana_gain);
        log_n++;
        repeat (3) @(negedge clk);
        ana_corr = corr_of(int'(ana_ch), int'(ana_gain));
        ana_ack  = 1'b1;
        @(negedge clk);
        ana_ack  = 1'b0;
      end
    end
  end

  // compare logged requests and store contents against what chen/gains imply
  task automatic verify_pass(logic [7:0] chen, logic [15:0] gains, int nreq, logic [3:0] vmask);
    int n = 0;
    int ech [8];
    int eg  [8];
    logic [3:0] seen = '0;
    for (int ch = 0; ch < 8; ch++) begin
      int g = int'(gains[2*ch +: 2]);
      if (chen[ch] && !seen[g]) begin
        ech[n] = ch; eg[n] = g; n++; seen[g] = 1'b1;
      end
    end
    check("R3 request count", 32'(log_n), 32'(nreq));
    check("R4 gain mask", 32'(seen), 32'(vmask));
    for (int i = 0; i < n && i < log_n; i++) begin
      check("R3 channel order", 32'(log_ch[i]), 32'(ech[i]));
      check("R4 gain of request", 32'(log_g[i]), 32'(eg[i]));
    end
    for (int g = 0; g < 4; g++) begin
      int first = -1;
      for (int i = n - 1; i >= 0; i--) if (eg[i] == g) first = ech[i];
      conv_gain = g[1:0];
      #1;
      check("R6 entry valid", 32'(conv_valid), 32'(vmask[g]));
      if (vmask[g]) check("R6 entry value", 32'(conv_corr), 32'(corr_of(first, g)));
    end
  endtask

  task automatic run_pass(logic [7:0] chen, logic [15:0] gains);
    wr(2'd0, 16'h0001);
    wr(2'd1, {8'h00, chen});
    wr(2'd2, gains);
    log_n = 0;
    wr(2'd0, 16'h0002);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    rd(2'd0, d);
    check("R11 status after reset", 32'(d[2:0]), 32'd0);
    check("R11 busy after reset", 32'(cal_busy), 32'd0);
    check("R11 irq after reset", 32'(irq), 32'd0);
    for (int g = 0; g < 4; g++) begin
      conv_gain = g[1:0]; #1;
      check("R11 entry invalid", 32'(conv_valid), 32'd0);
    end

    // R1 start without prior soft reset is ignored
    wr(2'd1, 16'h00FF);
    log_n = 0;
    wr(2'd0, 16'h0002);
    check("R1 unarmed start busy", 32'(cal_busy), 32'd0);
    repeat (10) @(negedge clk);
    check("R1 unarmed start requests", 32'(log_n), 32'd0);
    // R1 soft reset together with start: start dropped
    wr(2'd0, 16'h0003);
    check("R1 combined write busy", 32'(cal_busy), 32'd0);
    rd(2'd0, d);
    check("R9 armed after soft reset", 32'(d[2]), 32'd1);

    // table of patterns
    for (int v = 0; v < 5; v++) begin
      run_pass(VECS[v][31:24], VECS[v][23:8]);
      check("R2 busy after start", 32'(cal_busy), 32'd1);
      wait_idle("R2 pass ends");
      check("R8 irq masked", 32'(irq), 32'd0);
      rd(2'd0, d);
      check("R7 eoc set", 32'(d[1:0]), 32'b01);
      rd(2'd0, d);
      check("R7 eoc cleared by read", 32'(d[0]), 32'd0);
      verify_pass(VECS[v][31:24], VECS[v][23:8], int'(VECS[v][7:4]), VECS[v][3:0]);
    end

    // R1 second start after a pass with no soft reset
    log_n = 0;
    wr(2'd0, 16'h0002);
    check("R1 restart without reset", 32'(cal_busy), 32'd0);
    repeat (10) @(negedge clk);
    check("R1 restart requests", 32'(log_n), 32'd0);

    // R10 mode write leaves store; store holds pattern 4 (all gains valid)
    wr(2'd0, 16'h0024);
    rd(2'd3, d);
    check("R10 mode readback", 32'(d[5:4]), 32'd2);
    for (int g = 0; g < 4; g++) begin
      conv_gain = g[1:0]; #1;
      check("R10 entry kept", 32'(conv_valid), 32'd1);
      check("R10 value kept", 32'(conv_corr), 32'(corr_of(4 + g, g)));
    end

    // R2 start writes during busy have no effect
    run_pass(8'hFF, 16'hE4E4);
    wr(2'd0, 16'h0002);
    wr(2'd0, 16'h0002);
    check("R2 still busy", 32'(cal_busy), 32'd1);
    wait_idle("R2 pass ends once");
    verify_pass(8'hFF, 16'hE4E4, 4, 4'hF);

    // R5 configuration rewritten mid-pass does not alter the pass
    run_pass(8'h81, 16'h8001);
    repeat (2) @(negedge clk);
    wr(2'd1, 16'h0001);
    wr(2'd2, 16'h0000);
    wait_idle("R5 pass ends");
    verify_pass(8'h81, 16'h8001, 2, 4'h6);
    rd(2'd0, d);

    // R8 interrupt enabled
    wr(2'd3, 16'h0001);
    run_pass(8'h01, 16'h0000);
    wait_idle("R8 pass ends");
    @(negedge clk);
    check("R8 irq raised", 32'(irq), 32'd1);
    rd(2'd0, d);
    check("R8 irq cleared with eoc", 32'(irq), 32'd0);

    // R9 soft reset wipes all entries
    wr(2'd0, 16'h0001);
    for (int g = 0; g < 4; g++) begin
      conv_gain = g[1:0]; #1;
      check("R9 entry wiped", 32'(conv_valid), 32'd0);
    end

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule